// File: doc/BRIEF.md
# CPU Bus Cycle Stretcher

This block sits beside an 8-bit CPU and decides, for every bus cycle, whether that cycle runs at the full 2 MHz rate or is slowed to match a 1 MHz peripheral clock. Time is counted in slots. Each slot is one 2 MHz CPU period, and a one-clock `tick_2m` strobe marks the edge where one slot ends and the next begins. The `ph_1m` input tells the block, at each tick, whether the slot now starting is the first half of a 1 MHz period.

At the first tick of each CPU cycle the block decodes the address and the valid strobe. A cycle that targets ROM, RAM or a fast I/O window finishes in one slot. A valid cycle that targets a slow window is held until the end of a complete 1 MHz period:

- If it starts aligned with a 1 MHz period, it takes two slots.
- If it starts mid-period, it first waits half a period and so takes three slots.

The CPU sees three registered outputs:

- a hold level;
- a slow-cycle flag;
- a one-clock enable that marks the edge where its cycle completes.

Top module: `bus_stretch`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `cpu_hold`, `cpu_slow` and `cpu_ce` are all 0.
- R2: A valid cycle whose upper address byte is below 0xFC, or equal to 0xFF, lasts one slot: `cpu_hold` and `cpu_slow` are 0 during it.
- R3: A valid cycle whose upper address byte is 0xFC or 0xFD (the 1 MHz expansion pages) is stretched, with `cpu_slow` high for its whole length.
- R4: In the I/O page 0xFE, offsets 0x08-0x1F (serial controller, serial processor, converter) and 0x40-0x7F (both interface adapters) are stretched. Every other offset, including 0xE0-0xFF, runs at full speed.
- R5: A stretched cycle that starts at a tick with `ph_1m`=1 lasts two slots: `cpu_hold` is 1 in the first slot and 0 in the second.
- R6: A stretched cycle that starts at a tick with `ph_1m`=0 lasts three slots: `cpu_hold` is 1 in the first two slots and 0 in the third.
- R7: A cycle with `acc_valid`=0 at its starting tick is never stretched, whatever its address.
- R8: The tick that ends a stretched cycle starts a new cycle, which is decoded afresh and may run at full speed at once.
- R9: `cpu_ce` is high for exactly one clock, the clock right after each tick that ends a CPU cycle. It is 0 at all other times.
- R10: `cpu_hold` and `cpu_slow` change only on the clock edge of a tick. Address and valid values presented between ticks, or at ticks inside a stretched cycle, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_2m | input | 1 | One-clock strobe at each 2 MHz slot boundary |
| ph_1m | input | 1 | At a tick: 1 if the new slot is the first half of a 1 MHz period |
| cpu_addr | input | ADDR_W (16) | CPU address, sampled at the starting tick of a cycle |
| acc_valid | input | 1 | The cycle is a real bus access |
| cpu_hold | output | 1 | CPU must not complete its cycle at the end of this slot |
| cpu_slow | output | 1 | The current cycle is a stretched 1 MHz cycle |
| cpu_ce | output | 1 | One-clock pulse after the tick that completes a CPU cycle |

## Verification
A wrong remaining-slot count or a wrong phase decision shows up at the ports one clock after the next tick. It appears as a `cpu_hold` that stays high for one slot too long or too short, and `cpu_ce` lands in the wrong slot. A wrong entry in the decode table first shows up as a wrong `cpu_slow` on the clock after the starting tick of an access to that offset. Each offset of page 0xFE is applied as the start of a cycle, so every table entry is exposed. Addresses presented while a cycle is held change nothing at the ports, so a design that samples the address at the wrong time diverges within one slot.

// File: rtl/bus_stretch_pkg.sv
package bus_stretch_pkg;

  // Offsets inside the I/O page are grouped in blocks of eight bytes.
  localparam int BLK_BYTES_LOG2 = 3;
  localparam int BLK_COUNT      = 32;

  // Blocks 1..3 (0x08-0x1F) and 8..15 (0x40-0x7F) sit on the slow side.
  localparam logic [BLK_COUNT-1:0] DEF_SLOW_BLOCKS = 32'h0000_FF0E;

  localparam logic [7:0] DEF_IO_PAGE  = 8'hFE;
  localparam logic [7:0] DEF_EXP_PAGE = 8'hFC;   // this page and the next one

  // Decode result for one CPU cycle.
  typedef struct packed {
    logic stretch;   // cycle must follow the 1 MHz clock
    logic exp_bus;   // hit on the expansion pages
    logic io_blk;    // hit on a slow block inside the I/O page
  } dec_t;

  // Every address-to-speed decision is made here.
  function automatic dec_t classify(
    input logic [7:0]           page,
    input logic [7:0]           offs,
    input logic                 valid,
    input logic [7:0]           io_page,
    input logic [7:0]           exp_page,
    input logic [BLK_COUNT-1:0] slow_blocks
  );
    dec_t d;
    logic [4:0] blk;
    blk       = offs[7:BLK_BYTES_LOG2];
    d.exp_bus = (page[7:1] == exp_page[7:1]);
    d.io_blk  = (page == io_page) && slow_blocks[blk];
    d.stretch = valid && (d.exp_bus || d.io_blk);
    return d;
  endfunction

endpackage

// File: rtl/bus_stretch_decode.sv
module bus_stretch_decode
  import bus_stretch_pkg::*;
#(
  parameter int                   ADDR_W      = 16,
  parameter logic [7:0]           IO_PAGE     = DEF_IO_PAGE,
  parameter logic [7:0]           EXP_PAGE    = DEF_EXP_PAGE,
  parameter logic [BLK_COUNT-1:0] SLOW_BLOCKS = DEF_SLOW_BLOCKS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  output logic              stretch
);
  dec_t d;

  always_comb begin
    d       = classify(addr[ADDR_W-1 -: 8], addr[7:0], valid,
                       IO_PAGE, EXP_PAGE, SLOW_BLOCKS);
    stretch = d.stretch;
  end
endmodule

// File: rtl/bus_stretch_phase.sv
module bus_stretch_phase #(
  parameter int SLOT_RATIO = 2,
  parameter int CNT_W      = $clog2(SLOT_RATIO + 1)
) (
  input  logic             aligned,
  output logic [CNT_W-1:0] held_slots
);
  // Held slots = one full slow period minus the final slot, plus one more
  // slot when the access has to wait for the next period to begin.
  localparam logic [CNT_W-1:0] BASE_HELD = CNT_W'(SLOT_RATIO - 1);

  always_comb begin
    held_slots = aligned ? BASE_HELD : BASE_HELD + CNT_W'(1);
  end
endmodule

// File: rtl/bus_stretch_seq.sv
module bus_stretch_seq #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             stretch,
  input  logic [CNT_W-1:0] load,
  output logic             hold_q,
  output logic             slow_q,
  output logic             ce_q
);
  logic [CNT_W-1:0] left_q;
  logic             at_bound;

  assign at_bound = (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      hold_q <= 1'b0;
      slow_q <= 1'b0;
      ce_q   <= 1'b0;
    end else begin
      ce_q <= tick && at_bound;
      if (tick) begin
        if (at_bound) begin
          if (stretch) begin
            left_q <= load;
            hold_q <= (load != '0);
            slow_q <= 1'b1;
          end else begin
            hold_q <= 1'b0;
            slow_q <= 1'b0;
          end
        end else begin
          left_q <= left_q - CNT_W'(1);
          hold_q <= (left_q != CNT_W'(1));
        end
      end
    end
  end
endmodule

// File: rtl/bus_stretch.sv
module bus_stretch
  import bus_stretch_pkg::*;
#(
  parameter int                   ADDR_W      = 16,
  parameter int                   SLOT_RATIO  = 2,
  parameter logic [7:0]           IO_PAGE     = DEF_IO_PAGE,
  parameter logic [7:0]           EXP_PAGE    = DEF_EXP_PAGE,
  parameter logic [BLK_COUNT-1:0] SLOW_BLOCKS = DEF_SLOW_BLOCKS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_2m,
  input  logic              ph_1m,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              acc_valid,
  output logic              cpu_hold,
  output logic              cpu_slow,
  output logic              cpu_ce
);
  localparam int CNT_W = $clog2(SLOT_RATIO + 1);

  logic             stretch;
  logic [CNT_W-1:0] held;

  bus_stretch_decode #(
    .ADDR_W(ADDR_W), .IO_PAGE(IO_PAGE), .EXP_PAGE(EXP_PAGE),
    .SLOW_BLOCKS(SLOW_BLOCKS)
  ) u_dec (
    .addr(cpu_addr), .valid(acc_valid), .stretch(stretch)
  );

  bus_stretch_phase #(.SLOT_RATIO(SLOT_RATIO), .CNT_W(CNT_W)) u_ph (
    .aligned(ph_1m), .held_slots(held)
  );

  bus_stretch_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .tick(tick_2m), .stretch(stretch), .load(held),
    .hold_q(cpu_hold), .slow_q(cpu_slow), .ce_q(cpu_ce)
  );
endmodule

// File: rtl/bus_stretch_chk.sv
module bus_stretch_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_2m,
  input logic              ph_1m,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              acc_valid,
  input logic              cpu_hold,
  input logic              cpu_slow,
  input logic              cpu_ce
);
  // R1: outputs cleared by reset
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!cpu_hold && !cpu_slow && !cpu_ce));

  // R2: low memory and ROM never stretch
  a_r2_fast_mem: assert property (@(posedge clk) disable iff (rst)
    (tick_2m && !cpu_hold && acc_valid && cpu_addr[ADDR_W-1 -: 8] < 8'hFC)
    |=> (!cpu_slow && !cpu_hold));

  // R3: expansion pages always stretch
  a_r3_exp_slow: assert property (@(posedge clk) disable iff (rst)
    (tick_2m && !cpu_hold && acc_valid && cpu_addr[ADDR_W-1 -: 7] == 7'b1111110)
    |=> (cpu_slow && cpu_hold));

  // R7: no stretch without a valid access
  a_r7_idle_fast: assert property (@(posedge clk) disable iff (rst)
    (tick_2m && !cpu_hold && !acc_valid) |=> (!cpu_slow && !cpu_hold));

  // R9: enable only after a tick at a cycle end
  a_r9_ce_place: assert property (@(posedge clk) disable iff (rst)
    cpu_ce |-> ($past(tick_2m) && !$past(cpu_hold)));

  // R10: no output change between ticks
  a_r10_tick_only: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick_2m)) |-> ($stable(cpu_hold) && $stable(cpu_slow)));
endmodule

bind bus_stretch bus_stretch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick_2m(tick_2m), .ph_1m(ph_1m), .cpu_addr(cpu_addr),
  .acc_valid(acc_valid), .cpu_hold(cpu_hold), .cpu_slow(cpu_slow), .cpu_ce(cpu_ce)
);

// File: tb/tb_bus_stretch.sv
module tb_bus_stretch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_2m = 1'b0;
  logic        ph_1m = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        acc_valid = 1'b0;
  logic        cpu_hold, cpu_slow, cpu_ce;

  always #2.5 clk = ~clk;   // 200 MHz

  bus_stretch dut (
    .clk(clk), .rst(rst), .tick_2m(tick_2m), .ph_1m(ph_1m), .cpu_addr(cpu_addr),
    .acc_valid(acc_valid), .cpu_hold(cpu_hold), .cpu_slow(cpu_slow), .cpu_ce(cpu_ce)
  );

  int    n_vec = 0, n_bad = 0;
  int    m_pos = 0, m_len = 1;
  bit    m_hold = 0, m_slow = 0, m_ce = 0, m_prev_slow = 0;
  bit    m_tick_seen = 0, started = 0;
  string m_req = "R1";
  logic [16:0] vq[$];

  // Slow windows, written from the requirements (R3, R4).
  function automatic bit ref_slow(input logic [15:0] a);
    int hi, lo;
    hi = a[15:8];
    lo = a[7:0];
    if (hi == 'hFC || hi == 'hFD) return 1;
    if (hi != 'hFE) return 0;
    return (lo >= 'h08 && lo <= 'h1F) || (lo >= 'h40 && lo <= 'h7F);
  endfunction

  // Behavioural reference: cycle length in slots and position in it.
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_pos = 0; m_len = 1; m_hold = 0; m_slow = 0; m_ce = 0;
      m_req = "R1"; m_tick_seen = 0; m_prev_slow = 0;
    end else begin
      m_ce = tick_2m && (m_pos == m_len - 1);   // R9
      m_tick_seen = tick_2m;
      if (tick_2m) begin
        if (m_pos == m_len - 1) begin
          m_prev_slow = (m_len > 1);
          m_pos = 0;
          if (acc_valid && ref_slow(cpu_addr)) begin
            m_len = ph_1m ? 2 : 3;                          // R5 / R6
            m_req = (cpu_addr[15:8] != 8'hFE) ? "R3" : (ph_1m ? "R5" : "R6");
          end else begin
            m_len = 1;
            if (!acc_valid) m_req = "R7";
            else if (m_prev_slow) m_req = "R8";
            else if (cpu_addr[15:8] == 8'hFE) m_req = "R4";
            else m_req = "R2";
          end
        end else begin
          m_pos++;
        end
        m_hold = (m_pos < m_len - 1);
        m_slow = (m_len > 1);
      end
    end
  end

  int tdiv = 0;
  int cyc  = 0;

  initial begin
    // R4: every offset of the I/O page as a valid cycle start
    for (int i = 0; i < 256; i++) vq.push_back({1'b1, 8'hFE, 8'(i)});
    // R7: slow addresses without a valid strobe
    for (int i = 0; i < 256; i += 8) vq.push_back({1'b0, 8'hFE, 8'(i)});
    vq.push_back({1'b0, 16'hFC10});
    // R3: expansion pages, back to back with fast accesses (R8)
    vq.push_back({1'b1, 16'hFC00}); vq.push_back({1'b1, 16'h3000});
    vq.push_back({1'b1, 16'hFD80}); vq.push_back({1'b1, 16'hFDFF});
    vq.push_back({1'b1, 16'hFC55}); vq.push_back({1'b1, 16'hFE41});
    // R2: memory and ROM
    vq.push_back({1'b1, 16'h0000}); vq.push_back({1'b1, 16'h7FFF});
    vq.push_back({1'b1, 16'h8000}); vq.push_back({1'b1, 16'hC000});
    vq.push_back({1'b1, 16'hFBFF}); vq.push_back({1'b1, 16'hFF00});
    vq.push_back({1'b1, 16'hFFFF});
    for (int k = 0; k < 40; k++) vq.push_back({1'b1, 16'hFE60 + 16'(k % 3)});

    repeat (5) @(negedge clk);
    rst = 1'b0;   // R1 is compared while reset is held and just after
    while (vq.size() > 0 || cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog: run did not end, got %0d cycles expected < 100000", cyc);
        break;
      end
      if (tick_2m) ph_1m = ~ph_1m;
      tdiv = (tdiv + 1) % 4;
      tick_2m = (tdiv == 3);
      if (tick_2m && m_pos == m_len - 1 && vq.size() > 0) begin
        {acc_valid, cpu_addr} = vq.pop_front();
      end else begin
        // R10: noise between ticks and inside held cycles must be ignored
        acc_valid = 1'($urandom);
        cpu_addr  = 16'($urandom);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (started) begin
      string tag;
      n_vec++;
      if (cpu_ce !== m_ce) tag = "R9";
      else if (!rst && !m_tick_seen) tag = "R10";
      else tag = m_req;
      if (cpu_hold !== m_hold || cpu_slow !== m_slow || cpu_ce !== m_ce) begin
        n_bad++;
        $display("FAIL %s at %0t: hold/slow/ce got %b%b%b expected %b%b%b",
                 tag, $time, cpu_hold, cpu_slow, cpu_ce, m_hold, m_slow, m_ce);
      end
    end
  end
endmodule